// File: doc/BRIEF.md
# Element Saturation Clamp

This block takes one integer element result that arithmetic upstream has produced at the wider of the source and destination element widths. It squeezes that value into the destination element width, which may be 8, 16, 32 or 64 bits. A mode input picks the range: unsigned (zero up to all ones) or signed two's complement. The block also reports whether the value had to be clamped, so that a per-element condition field can record it.

Next to the clamped value, the block produces three status outputs. A carry-undefined flag tells the writeback logic that carry bits are meaningless whenever saturation is requested. An illegal-instruction flag is raised when saturation is combined with the overflow-enable instruction bit. The saturation flag depends only on the current element: no sticky summary-overflow state is read or merged.

The intermediate is 65 bits wide and signed, so both a negative value and a full unsigned 64-bit value can be represented. A separate input marks the case where even the intermediate has wrapped. Because a parameter adds a register stage at the output, the block can sit at a pipeline boundary.

Top module: `satclamp_unit`

## Requirements
- R1: With saturation enabled and `signed_i`=0, an element whose value lies below zero produces 0. A value above 2^w-1 produces 2^w-1. Any other value is passed through unchanged. Here w is the destination width.
- R2: With saturation enabled and `signed_i`=1, the value is clamped to the range -2^(w-1) .. 2^(w-1)-1. The result is given as w-bit two's complement, so the minimum for w=8 is 0x80.
- R3: `width_sel_i` selects w as follows: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64. Bits of `elem_o` above bit w-1 are always 0.
- R4: When `wide_ovf_i`=1, the intermediate has wrapped, so the true sign is the inverse of bit 64. With saturation enabled, the element then clamps to the maximum if bit 64 is 1 and to the minimum if bit 64 is 0, and it always counts as clamped.
- R5: `sat_flag_o` is 1 exactly when saturation is enabled, `rc_i`=1 and the element was clamped. With `rc_i`=0 it is 0. It depends on the current element only and carries nothing over from earlier elements.
- R6: `illegal_o` equals `sat_en_i` AND `oe_i`.
- R7: `carry_undef_o` equals `sat_en_i`.
- R8: With `sat_en_i`=0, `elem_o` is the low w bits of the intermediate, and `sat_flag_o`, `illegal_o` and `carry_undef_o` are 0, whatever the mode, `rc_i` and `oe_i` are.
- R9: With `REG_OUT`=1, every output reflects the inputs sampled at the previous rising clock edge. While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sat_en_i | input | 1 | Saturation requested for this element |
| wide_i | input | 65 | Signed intermediate result |
| wide_ovf_i | input | 1 | Intermediate itself wrapped; true sign is inverse of bit 64 |
| width_sel_i | input | 2 | Destination width code (0:8, 1:16, 2:32, 3:64) |
| signed_i | input | 1 | 1 selects signed range, 0 unsigned |
| rc_i | input | 1 | Condition recording enabled |
| oe_i | input | 1 | Overflow-enable instruction bit |
| elem_o | output | 64 | Clamped element, zero above the selected width |
| sat_flag_o | output | 1 | Clamping occurred (condition-field overflow bit) |
| carry_undef_o | output | 1 | Carry outputs are not valid |
| illegal_o | output | 1 | Illegal-instruction indication |

## Verification
The bench builds the block with its default parameters. These are an 8-bit minimum width, four width steps up to 64 bits, a 65-bit intermediate and `REG_OUT`=1. Every width code can therefore be driven, including the 64-bit case, where the unsigned maximum is all ones and only bit 64 signals overflow. With the registered stage, the bench can show that the output still holds the previous element just before the clock edge. It can also show that reset clears the outputs.

// File: rtl/satclamp_pkg.sv
package satclamp_pkg;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } sat_mode_e;

    // Width in bits of the lane selected by a width code.
    function automatic int unsigned lane_width(int unsigned min_w, int unsigned sel);
        return min_w << sel;
    endfunction

endpackage

// File: rtl/satclamp_fit.sv
// Per-width range test of the intermediate: does it fit unsigned / signed?
module satclamp_fit #(
    parameter int MIN_W  = 8,
    parameter int NUM_W  = 4,
    parameter int WIDE_W = 65
) (
    input  logic [WIDE_W-1:0] val_i,
    output logic [NUM_W-1:0]  fit_u_o,
    output logic [NUM_W-1:0]  fit_s_o
);
    for (genvar k = 0; k < NUM_W; k++) begin : g_lane
        localparam int W = int'(satclamp_pkg::lane_width(MIN_W, k));
        // Unsigned fit: everything from bit W upward is zero (covers sign too).
        assign fit_u_o[k] = (val_i[WIDE_W-1:W] == '0);
        // Signed fit: bits W-1 and up are all copies of one sign bit.
        assign fit_s_o[k] = (val_i[WIDE_W-1:W-1] == '0) || (&val_i[WIDE_W-1:W-1]);
    end
endmodule

// File: rtl/satclamp_limits.sv
// Lane mask and clamp bounds for the selected width and mode.
module satclamp_limits #(
    parameter int MIN_W = 8,
    parameter int NUM_W = 4,
    parameter int MAX_W = 64,
    parameter int SEL_W = 2
) (
    input  logic [SEL_W-1:0] sel_i,
    input  satclamp_pkg::sat_mode_e mode_i,
    output logic [MAX_W-1:0] mask_o,
    output logic [MAX_W-1:0] hi_o,
    output logic [MAX_W-1:0] lo_o
);
    logic [MAX_W-1:0] masks [NUM_W];

    for (genvar k = 0; k < NUM_W; k++) begin : g_mask
        localparam int W = int'(satclamp_pkg::lane_width(MIN_W, k));
        if (W == MAX_W) begin : g_full
            assign masks[k] = '1;
        end else begin : g_part
            assign masks[k] = {{(MAX_W-W){1'b0}}, {W{1'b1}}};
        end
    end

    always_comb begin
        mask_o = masks[sel_i];
        if (mode_i == satclamp_pkg::MODE_SIGNED) begin
            hi_o = mask_o >> 1;
            lo_o = mask_o ^ (mask_o >> 1);
        end else begin
            hi_o = mask_o;
            lo_o = '0;
        end
    end
endmodule

// File: rtl/satclamp_unit.sv
module satclamp_unit #(
    parameter int MIN_W   = 8,
    parameter int NUM_W   = 4,
    parameter bit REG_OUT = 1'b1,
    localparam int MAX_W  = MIN_W << (NUM_W - 1),
    localparam int WIDE_W = MAX_W + 1,
    localparam int SEL_W  = (NUM_W > 1) ? $clog2(NUM_W) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sat_en_i,
    input  logic [WIDE_W-1:0] wide_i,
    input  logic              wide_ovf_i,
    input  logic [SEL_W-1:0]  width_sel_i,
    input  logic              signed_i,
    input  logic              rc_i,
    input  logic              oe_i,
    output logic [MAX_W-1:0]  elem_o,
    output logic              sat_flag_o,
    output logic              carry_undef_o,
    output logic              illegal_o
);
    typedef struct packed {
        logic [MAX_W-1:0] elem;
        logic             sat;
        logic             cu;
        logic             ill;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_W-1:0] fit_u, fit_s;
    logic [MAX_W-1:0] mask, hi, lo;
    satclamp_pkg::sat_mode_e mode;

    assign mode = satclamp_pkg::sat_mode_e'(signed_i);

    satclamp_fit #(.MIN_W(MIN_W), .NUM_W(NUM_W), .WIDE_W(WIDE_W)) u_fit (
        .val_i   (wide_i),
        .fit_u_o (fit_u),
        .fit_s_o (fit_s)
    );

    satclamp_limits #(.MIN_W(MIN_W), .NUM_W(NUM_W), .MAX_W(MAX_W), .SEL_W(SEL_W)) u_lim (
        .sel_i  (width_sel_i),
        .mode_i (mode),
        .mask_o (mask),
        .hi_o   (hi),
        .lo_o   (lo)
    );

    always_comb begin
        logic neg;
        logic fits;
        logic in_range;
        out_d    = '0;
        neg      = wide_ovf_i ? ~wide_i[WIDE_W-1] : wide_i[WIDE_W-1];
        fits     = (mode == satclamp_pkg::MODE_SIGNED) ? fit_s[width_sel_i] : fit_u[width_sel_i];
        in_range = !wide_ovf_i && fits;
        if (sat_en_i) begin
            out_d.elem = in_range ? (wide_i[MAX_W-1:0] & mask) : (neg ? lo : hi);
            out_d.sat  = rc_i && !in_range;
            out_d.cu   = 1'b1;
            out_d.ill  = oe_i;
        end else begin
            out_d.elem = wide_i[MAX_W-1:0] & mask;
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) out_q <= '0;
            else         out_q <= out_d;
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign elem_o        = out_q.elem;
    assign sat_flag_o    = out_q.sat;
    assign carry_undef_o = out_q.cu;
    assign illegal_o     = out_q.ill;
endmodule

// File: rtl/satclamp_checker.sv
module satclamp_checker #(
    parameter int MIN_W   = 8,
    parameter int NUM_W   = 4,
    parameter bit REG_OUT = 1'b1,
    parameter int MAX_W   = 64,
    parameter int WIDE_W  = 65,
    parameter int SEL_W   = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sat_en_i,
    input logic [WIDE_W-1:0] wide_i,
    input logic              wide_ovf_i,
    input logic [SEL_W-1:0]  width_sel_i,
    input logic              signed_i,
    input logic              rc_i,
    input logic              oe_i,
    input logic [MAX_W-1:0]  elem_o,
    input logic              sat_flag_o,
    input logic              carry_undef_o,
    input logic              illegal_o
);
    function automatic logic [MAX_W-1:0] lane_mask(logic [SEL_W-1:0] s);
        int unsigned w;
        w = satclamp_pkg::lane_width(MIN_W, s);
        return (MAX_W'(1) << w) - MAX_W'(1);
    endfunction

    logic seen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seen_q <= 1'b0;
        else         seen_q <= 1'b1;
    end

    if (REG_OUT) begin : g_chk
        assert_illegal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            seen_q |-> (illegal_o == $past(sat_en_i && oe_i)));

        assert_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            seen_q |-> (carry_undef_o == $past(sat_en_i)));

        assert_flag_needs_rc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (seen_q && sat_flag_o) |-> $past(rc_i && sat_en_i));

        assert_lane_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            seen_q |-> ((elem_o & ~lane_mask($past(width_sel_i))) == '0));

        assert_bypass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (seen_q && !$past(sat_en_i)) |->
                (elem_o == ($past(wide_i[MAX_W-1:0]) & lane_mask($past(width_sel_i)))));

        assert_ovf_clamps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (seen_q && $past(sat_en_i && wide_ovf_i && rc_i)) |-> sat_flag_o);

        assert_unsigned_neg_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (seen_q && $past(sat_en_i && !signed_i && !wide_ovf_i && wide_i[WIDE_W-1]))
                |-> (elem_o == '0));
    end
endmodule

bind satclamp_unit satclamp_checker #(
    .MIN_W(MIN_W), .NUM_W(NUM_W), .REG_OUT(REG_OUT),
    .MAX_W(MAX_W), .WIDE_W(WIDE_W), .SEL_W(SEL_W)
) u_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .sat_en_i(sat_en_i), .wide_i(wide_i),
    .wide_ovf_i(wide_ovf_i), .width_sel_i(width_sel_i), .signed_i(signed_i),
    .rc_i(rc_i), .oe_i(oe_i), .elem_o(elem_o), .sat_flag_o(sat_flag_o),
    .carry_undef_o(carry_undef_o), .illegal_o(illegal_o)
);

// File: tb/satclamp_unit_bench.sv
module satclamp_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sat_en = 1'b0;
    logic [64:0] wide = '0;
    logic        wovf = 1'b0;
    logic [1:0]  wsel = '0;
    logic        sgn = 1'b0;
    logic        rc = 1'b0;
    logic        oe = 1'b0;
    logic [63:0] elem;
    logic        sflag, cundef, ill;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    satclamp_unit u_satclamp_unit (
        .clk_i(clk), .rst_ni(rst_n), .sat_en_i(sat_en), .wide_i(wide),
        .wide_ovf_i(wovf), .width_sel_i(wsel), .signed_i(sgn), .rc_i(rc),
        .oe_i(oe), .elem_o(elem), .sat_flag_o(sflag),
        .carry_undef_o(cundef), .illegal_o(ill)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent model of the requirements.
    task automatic model(output logic [63:0] e_elem, output logic e_flag,
                         output logic e_cu, output logic e_ill);
        int unsigned w;
        logic [63:0] m;
        logic signed [66:0] v, uhi, shi, slo;
        logic clamped;
        w   = 8 << wsel;
        m   = (64'd1 << w) - 64'd1;
        v   = $signed(wide);
        uhi = $signed({3'b000, m});
        shi = $signed({3'b000, m >> 1});
        slo = -shi - 67'sd1;
        clamped = 1'b0;
        e_elem = wide[63:0] & m;
        if (sat_en) begin
            if (wovf) begin
                clamped = 1'b1;
                if (wide[64]) e_elem = sgn ? shi[63:0] : m;
                else          e_elem = sgn ? (slo[63:0] & m) : 64'd0;
            end else if (!sgn) begin
                if (v < 0)        begin clamped = 1'b1; e_elem = 64'd0; end
                else if (v > uhi) begin clamped = 1'b1; e_elem = m; end
            end else begin
                if (v < slo)      begin clamped = 1'b1; e_elem = slo[63:0] & m; end
                else if (v > shi) begin clamped = 1'b1; e_elem = shi[63:0]; end
            end
        end
        e_flag = sat_en && rc && clamped;
        e_cu   = sat_en;
        e_ill  = sat_en && oe;
    endtask

    // Drive one element, wait for the registered stage (R9), check all outputs.
    task automatic run(string req, logic en, logic [64:0] v, logic ov,
                       logic [1:0] s, logic n, logic r, logic o);
        logic [63:0] e; logic f, c, i;
        sat_en = en; wide = v; wovf = ov; wsel = s; sgn = n; rc = r; oe = o;
        model(e, f, c, i);
        @(posedge clk); #1;
        check({req, " elem"}, elem, e);
        check({req, " sat_flag"}, 64'(sflag), 64'(f));
        check({req, " carry_undef R7"}, 64'(cundef), 64'(c));
        check({req, " illegal R6"}, 64'(ill), 64'(i));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        sat_en = 1'b1; wide = 65'h1_FFFF_FFFF_FFFF_FFFF; rc = 1'b1; oe = 1'b1;
        @(posedge clk); #1;
        check("R9 reset elem", elem, 64'd0);
        check("R9 reset flags", 64'({sflag, cundef, ill}), 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_unsigned;
        run("R1 in range",   1, 65'd200,  0, 0, 0, 1, 0);
        run("R1 above max",  1, 65'd256,  0, 0, 0, 1, 0);
        run("R1 negative",   1, -65'sd1,  0, 0, 0, 1, 0);
        run("R1 16 big",     1, 65'h12345, 0, 1, 0, 1, 0);
        run("R1 64 max",     1, 65'h0_FFFF_FFFF_FFFF_FFFF, 0, 3, 0, 1, 0);
        run("R1 64 over",    1, 65'h1_0000_0000_0000_0000, 0, 3, 0, 1, 0);
    endtask

    task automatic t_signed;
        run("R2 max edge",   1, 65'd127,   0, 0, 1, 1, 0);
        run("R2 above max",  1, 65'd128,   0, 0, 1, 1, 0);
        run("R2 min edge",   1, -65'sd128, 0, 0, 1, 1, 0);
        run("R2 below min",  1, -65'sd129, 0, 0, 1, 1, 0);
        run("R2 32 neg in",  1, -65'sd5,   0, 2, 1, 1, 0);
        run("R2 64 over",    1, 65'h0_8000_0000_0000_0000, 0, 3, 1, 1, 0);
        run("R2 64 under",   1, 65'h1_7FFF_FFFF_FFFF_FFFF, 0, 3, 1, 1, 0);
    endtask

    task automatic t_widths;
        for (int s = 0; s < 4; s++) begin
            run("R3 width lanes", 1, 65'h0_0000_0000_0000_0003, 0, 2'(s), 0, 0, 0);
            run("R3 width bypass", 0, 65'h1_A5A5_A5A5_A5A5_A5A5, 0, 2'(s), 1, 0, 0);
        end
    endtask

    task automatic t_wovf;
        run("R4 wrapped pos u", 1, 65'h1_0000_0000_0000_0005, 1, 1, 0, 1, 0);
        run("R4 wrapped neg u", 1, 65'h0_0000_0000_0000_0005, 1, 1, 0, 1, 0);
        run("R4 wrapped pos s", 1, 65'h1_0000_0000_0000_0005, 1, 0, 1, 1, 0);
        run("R4 wrapped neg s", 1, 65'h0_0000_0000_0000_0005, 1, 3, 1, 1, 0);
    endtask

    task automatic t_flag;
        run("R5 rc0 clamped",   1, 65'd999, 0, 0, 0, 0, 0);
        run("R5 clamp first",   1, 65'd999, 0, 0, 0, 1, 0);
        run("R5 no sticky",     1, 65'd9,   0, 0, 0, 1, 0);
        check("R5 no sticky flag", 64'(sflag), 64'd0);
    endtask

    task automatic t_status;
        run("R6 oe sat",      1, 65'd1, 0, 0, 0, 0, 1);
        run("R6 oe plain R8", 0, 65'd1, 0, 0, 0, 1, 1);
        run("R8 bypass big",  0, 65'h1_FFFF_FFFF_FFFF_FF00, 1, 0, 1, 1, 1);
    endtask

    task automatic t_latency;
        run("R9 first", 1, 65'd300, 0, 0, 0, 1, 0);
        wide = 65'd7; sat_en = 1'b0;
        #2;
        check("R9 holds before edge", elem, 64'd255);
        run("R9 second", 0, 65'd7, 0, 0, 0, 1, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_unsigned();
        t_signed();
        t_widths();
        t_wovf();
        t_flag();
        t_status();
        t_latency();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule